// File: doc/BRIEF.md
# UART Receiver with Request-to-Send Flow Control

This block is the receive half of an asynchronous serial port. It watches a serial line carrying frames of one start bit, eight data bits (least significant first) and one stop bit. A pulse on an external tick input marks each oversampling point, sixteen per bit. Each finished byte is placed in a one-entry holding register and a data-ready flag is raised. The flag stays up until the consumer issues a read strobe.

The holding register also paces the far-end sender through an active-low request-to-send output. When flow control is on, the output is low while the register is empty. It goes high as soon as a byte is waiting, so the sender stops after the frame it is currently sending. Framing, noise and overrun conditions are flagged alongside the byte. They reach a single interrupt line through an error enable, separate from the data-ready enable. A request output lets a DMA engine fetch bytes, and it takes over from the data-ready interrupt while it is enabled.

Top module: `uart_rx_flow`

## Requirements
- R1: On tick pulses, each bit is taken as the majority of three samples at tick counts 7, 8 and 9 after the falling edge that started the frame. The eight data bits are shifted in least significant bit first. At the stop bit the byte appears on `rx_data_o` and `rdy_o` goes to 1.
- R2: If the three samples of any bit (start, data or stop) disagree, `nf_o` is set to 1 together with `rdy_o` for that byte.
- R3: If the stop-bit majority is 0, `fe_o` is set to 1 and the byte is still stored and flagged ready.
- R4: If the start-bit majority is 1, the frame is abandoned as a glitch. No byte is stored and the receiver waits for a new falling edge.
- R5: If a byte completes while `rdy_o` is 1, `ore_o` is set to 1, `rx_data_o` keeps the older byte and the new byte is lost.
- R6: A one-cycle `rd_i` pulse while `rdy_o` is 1 clears `rdy_o`, `fe_o`, `nf_o` and `ore_o` in the next cycle. A pulse while `rdy_o` is 0 changes nothing.
- R7: With `rts_en_i` at 1, `rts_n_o` is 0 while `rdy_o` is 0 and 1 while `rdy_o` is 1, one cycle behind the enable input.
- R8: With `rts_en_i` at 0, `rts_n_o` stays at 1 whatever the state of the holding register.
- R9: `irq_o` is 1 when `rdy_o` is 1, `rdy_ie_i` is 1 and `dma_en_i` is 0. The data-ready cause is masked whenever `dma_en_i` is 1.
- R10: `irq_o` is 1 when `err_ie_i` is 1 and any of `fe_o`, `nf_o`, `ore_o` is 1, independent of `rdy_ie_i`.
- R11: `dma_req_o` equals `rdy_o` while `dma_en_i` is 1 and is 0 otherwise.
- R12: Synchronous reset clears `rdy_o`, all three error flags, `rx_data_o`, `irq_o` and `dma_req_o`, and drives `rts_n_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse per oversampling point (16 per bit) |
| rd_i | input | 1 | Read strobe for the holding register |
| rts_en_i | input | 1 | Enables request-to-send flow control |
| rdy_ie_i | input | 1 | Data-ready interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| dma_en_i | input | 1 | Enables the DMA request, masks the data-ready interrupt |
| rx_data_o | output | 8 | Held byte |
| rdy_o | output | 1 | Data-ready flag |
| fe_o | output | 1 | Framing error flag |
| nf_o | output | 1 | Noise flag |
| ore_o | output | 1 | Overrun flag |
| rts_n_o | output | 1 | Active-low request to send |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions check these relations on every cycle:
- `rts_n_o` tracks the holding flag and the enable.
- An overrun only exists with a byte held, and the held byte survives it.
- A read empties the register.
- The DMA request never appears without data, and the data-ready interrupt stays masked while DMA is enabled.
- A failed start sample sends the receiver back to idle.

Only the bench's frames can show that bits are assembled in the right order from majority samples. The same holds for a single flipped sample raising the noise flag, a low stop bit raising a framing error, and a short low pulse leaving no byte behind.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  typedef struct packed {
    logic frame;
    logic noise;
  } rx_err_t;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_s,
  input  logic              tick,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output rx_err_t           err_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] SMP_A = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SMP_B = CW'(OSR/2);
  localparam logic [CW-1:0] SMP_C = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_state_t         state;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [1:0]        smp;
  logic [DATA_W-1:0] shreg;
  logic              noise;
  logic              maj, dis;

  always_comb begin
    maj = (smp[0] & smp[1]) | (smp[0] & rx_s) | (smp[1] & rx_s);
    dis = !((smp[0] == smp[1]) && (smp[1] == rx_s));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      tcnt   <= '0;
      bidx   <= '0;
      smp    <= '0;
      shreg  <= '0;
      noise  <= 1'b0;
      done_o <= 1'b0;
      byte_o <= '0;
      err_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          if (!rx_s) begin
            state <= RX_START;
            tcnt  <= CW'(1);
            noise <= 1'b0;
          end
        end else begin
          tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
          if (tcnt == SMP_A) smp[0] <= rx_s;
          if (tcnt == SMP_B) smp[1] <= rx_s;
          if (tcnt == SMP_C) begin
            case (state)
              RX_START: begin
                if (maj) state <= RX_IDLE;
                else     noise <= noise | dis;
              end
              RX_DATA: begin
                shreg <= {maj, shreg[DATA_W-1:1]};
                noise <= noise | dis;
              end
              RX_STOP: begin
                done_o      <= 1'b1;
                byte_o      <= shreg;
                err_o.frame <= !maj;
                err_o.noise <= noise | dis;
                state       <= RX_IDLE;
              end
              default: state <= RX_IDLE;
            endcase
          end
          if (tcnt == LAST) begin
            if (state == RX_START) begin
              state <= RX_DATA;
              bidx  <= '0;
            end else if (state == RX_DATA) begin
              if (bidx == BLAST) state <= RX_STOP;
              else               bidx  <= bidx + 1'b1;
            end
          end
        end
      end
    end
  end

  // R4
  glitch_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick && tcnt == SMP_C && smp == 2'b11 && rx_s)
      |=> state == RX_IDLE);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/urx_holdreg.sv
module urx_holdreg
  import urx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  rx_err_t           err_i,
  input  logic              rd_i,
  input  logic              rts_en_i,
  input  logic              rdy_ie_i,
  input  logic              err_ie_i,
  input  logic              dma_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              fe_o,
  output logic              nf_o,
  output logic              ore_o,
  output logic              rts_n_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic [DATA_W-1:0] data_n;
  logic              rdy_n, fe_n, nf_n, ore_n;

  always_comb begin
    data_n = data_o;
    rdy_n  = rdy_o;
    fe_n   = fe_o;
    nf_n   = nf_o;
    ore_n  = ore_o;
    if (rd_i && rdy_o) begin
      rdy_n = 1'b0;
      fe_n  = 1'b0;
      nf_n  = 1'b0;
      ore_n = 1'b0;
    end
    if (done_i) begin
      if (rdy_n) begin
        ore_n = 1'b1;
      end else begin
        data_n = byte_i;
        rdy_n  = 1'b1;
        fe_n   = err_i.frame;
        nf_n   = err_i.noise;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      rdy_o     <= 1'b0;
      fe_o      <= 1'b0;
      nf_o      <= 1'b0;
      ore_o     <= 1'b0;
      rts_n_o   <= 1'b1;
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      data_o    <= data_n;
      rdy_o     <= rdy_n;
      fe_o      <= fe_n;
      nf_o      <= nf_n;
      ore_o     <= ore_n;
      rts_n_o   <= !rts_en_i || rdy_n;
      irq_o     <= (rdy_n && rdy_ie_i && !dma_en_i) ||
                   (err_ie_i && (fe_n || nf_n || ore_n));
      dma_req_o <= rdy_n && dma_en_i;
    end
  end

  // R5
  ovr_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    ore_o |-> rdy_o);

  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && done_i && !rd_i) |=> ($stable(data_o) && ore_o));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rdy_o && !done_i) |=> (!rdy_o && !fe_o && !nf_o && !ore_o));

  // R7
  rts_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rts_n_o == (!$past(rts_en_i) || rdy_o)));

  // R11
  dma_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> rdy_o);

  // R9
  dma_masks_rdy_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dma_en_i) && !$past(err_ie_i)) |-> !irq_o);
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
  import urx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              os_tick_i,
  input  logic              rd_i,
  input  logic              rts_en_i,
  input  logic              rdy_ie_i,
  input  logic              err_ie_i,
  input  logic              dma_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdy_o,
  output logic              fe_o,
  output logic              nf_o,
  output logic              ore_o,
  output logic              rts_n_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic              rx_s;
  logic              done;
  logic [DATA_W-1:0] rx_byte;
  rx_err_t           rx_err;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rx_i),
    .q_o (rx_s)
  );

  urx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_smp (
    .clk    (clk),
    .rst    (rst),
    .rx_s   (rx_s),
    .tick   (os_tick_i),
    .done_o (done),
    .byte_o (rx_byte),
    .err_o  (rx_err)
  );

  urx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done),
    .byte_i    (rx_byte),
    .err_i     (rx_err),
    .rd_i      (rd_i),
    .rts_en_i  (rts_en_i),
    .rdy_ie_i  (rdy_ie_i),
    .err_ie_i  (err_ie_i),
    .dma_en_i  (dma_en_i),
    .data_o    (rx_data_o),
    .rdy_o     (rdy_o),
    .fe_o      (fe_o),
    .nf_o      (nf_o),
    .ore_o     (ore_o),
    .rts_n_o   (rts_n_o),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );
endmodule

// File: tb/sim_uart_rx_flow.sv
module sim_uart_rx_flow;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       rd = 1'b0;
  logic       rts_en = 1'b1;
  logic       rdy_ie = 1'b0;
  logic       err_ie = 1'b0;
  logic       dma_en = 1'b0;
  logic [7:0] data;
  logic       rdy, fe, nf, ore, rts_n, irq, dreq;
  int         total = 0;
  int         bad = 0;
  int         tdiv = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  uart_rx_flow u0 (
    .clk(clk), .rst(rst), .rx_i(rx), .os_tick_i(tick), .rd_i(rd),
    .rts_en_i(rts_en), .rdy_ie_i(rdy_ie), .err_ie_i(err_ie), .dma_en_i(dma_en),
    .rx_data_o(data), .rdy_o(rdy), .fe_o(fe), .nf_o(nf), .ore_o(ore),
    .rts_n_o(rts_n), .irq_o(irq), .dma_req_o(dreq)
  );

  // tick every fourth clock, changed at the falling edge
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 3);
  end

  // {byte, stop level, noise on, noise bit index (0 start .. 9 stop)}
  localparam logic [13:0] VECS [7] = '{
    {8'hA5, 1'b1, 1'b0, 4'd0},
    {8'h00, 1'b1, 1'b0, 4'd0},
    {8'hFF, 1'b1, 1'b0, 4'd0},
    {8'h3C, 1'b1, 1'b1, 4'd3},
    {8'h81, 1'b0, 1'b0, 4'd0},
    {8'h5A, 1'b1, 1'b1, 4'd9},
    {8'h12, 1'b1, 1'b1, 4'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stopb, input logic nz, input int nzbit);
    for (int k = 0; k < 10; k++) begin
      logic v;
      v = (k == 0) ? 1'b0 : (k == 9) ? stopb : b[k-1];
      for (int c = 0; c < 64; c++) begin
        rx = (nz && k == nzbit && c >= 32 && c < 36) ? ~v : v;
        @(negedge clk);
      end
    end
    rx = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 rdy", rdy, 0);
    check("R12 rts_n", rts_n, 1);
    check("R12 data", data, 0);
    check("R12 irq", irq, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 rts_n empty", rts_n, 0);

    // R1 R2 R3 R6 R7 table
    for (int i = 0; i < 7; i++) begin
      logic [7:0] b;
      logic       st, nz;
      b  = VECS[i][13:6];
      st = VECS[i][5];
      nz = VECS[i][4];
      send(b, st, nz, int'(VECS[i][3:0]));
      check("R1 rdy", rdy, 1);
      check("R1 data", data, b);
      check("R3 fe", fe, !st);
      check("R2 nf", nf, nz);
      check("R5 no ore", ore, 0);
      check("R7 rts_n full", rts_n, 1);
      check("R9 irq off", irq, 0);
      do_read();
      check("R6 rdy clr", rdy, 0);
      check("R6 flags clr", {fe, nf, ore}, 0);
      check("R7 rts_n empty", rts_n, 0);
    end

    // R4 glitch
    rx = 1'b0;
    repeat (16) @(negedge clk);
    rx = 1'b1;
    repeat (700) @(negedge clk);
    check("R4 glitch no byte", rdy, 0);

    // R5 overrun, R6 read when empty
    send(8'h11, 1'b1, 1'b0, 0);
    send(8'h22, 1'b1, 1'b0, 0);
    check("R5 ore", ore, 1);
    check("R5 old kept", data, 8'h11);
    do_read();
    check("R6 ore clr", {rdy, ore}, 0);
    do_read();
    check("R6 empty read", {rdy, fe, nf, ore}, 0);
    check("R6 data kept", data, 8'h11);

    // R8 flow control off, R9 / R11
    rts_en = 1'b0;
    send(8'h33, 1'b1, 1'b0, 0);
    check("R8 rts_n off", rts_n, 1);
    rdy_ie = 1'b1;
    @(negedge clk);
    check("R9 irq", irq, 1);
    dma_en = 1'b1;
    @(negedge clk);
    check("R9 irq masked", irq, 0);
    check("R11 dma_req", dreq, 1);
    do_read();
    check("R11 dma_req clr", dreq, 0);
    check("R8 rts_n empty off", rts_n, 1);
    dma_en = 1'b0;
    rdy_ie = 1'b0;
    rts_en = 1'b1;

    // R10 error interrupt
    err_ie = 1'b1;
    send(8'h44, 1'b0, 1'b0, 0);
    check("R10 irq err", irq, 1);
    err_ie = 1'b0;
    @(negedge clk);
    check("R10 irq off", irq, 0);
    do_read();
    check("R6 final clr", rdy, 0);

    finish_run();
  end
endmodule